// File: doc/BRIEF.md
# Link and Interrupt Event Statistics Counters

This block keeps running totals of two kinds of link activity: how many times the link has been switched on, and how often each of eight interrupt sources has fired. Interrupt sources are counted from their raw event pulses, before any masking. The count is the same whether a source is enabled for interrupt delivery or not. While the link is off, interrupt pulses are not counted.

Software reads the totals through a small word-addressed register port. Each interrupt total is sixteen bits wide, and two of them share one 32-bit word. A single control word clears every total at once. Reads are combinational: read data follows the address in the same cycle and changes no state.

Top module: `link_evt_stats`

## Requirements
- R1: After reset, every counter is zero, and every mapped word reads 0x00000000.
- R2: The link counter increments by one on each cycle in which `link_en` is high after being low on the previous clock edge. Holding `link_en` high adds nothing more. The counter reads at word 0x0B1 in bits [15:0], with bits [31:16] zero.
- R3: The interrupt totals sit in words 0x0B4 to 0x0B7. Word 0x0B4+k holds source 2k in bits [15:0] and source 2k+1 in bits [31:16]. Each clock edge at which `irq_evt[i]` and `link_en` are both high adds one to total i.
- R4: While `link_en` is low, pulses on `irq_evt` leave every interrupt total unchanged.
- R5: A write to word 0x0B0 with data bit 0 set clears all nine counters. A write to 0x0B0 with bit 0 clear, or a write to any other address, changes no counter.
- R6: When a clear and an increment fall on the same edge, the clear wins and the counter reads zero afterwards.
- R7: Counters wrap modulo 2^16, so 0xFFFF plus one event gives 0x0000.
- R8: Word 0x0B0 and every unmapped address read as zero. Reading any address leaves every counter unchanged.
- R9: `reg_rdata` shows the word addressed by `reg_addr` in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Link enable level |
| irq_evt | input | 8 | Raw interrupt event pulses, one per source, taken before masking |
| reg_addr | input | 10 | Word address of the register port |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data; only bit 0 of the control word has an effect |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
The hardest case to reach from the ports is the wrap from 0xFFFF to zero. It needs 65,536 counted events on a single source without a clear. The stimulus holds the link on and one interrupt line high for 65,535 consecutive cycles, reads back 0xFFFF, then adds one more cycle and expects zero. A second hard case is a clear that lands on the same edge as a link rising edge and as every interrupt line firing. The stimulus builds up nonzero totals first, so that a lost clear would show in the readback.

// File: rtl/lstat_pkg.sv
// Package: shared constants for the link/interrupt statistics block.
// Assumes word addressing and two 16-bit counters per 32-bit word.
package lstat_pkg;
    localparam int LS_ADDR_W    = 10;
    localparam int LS_DATA_W    = 32;
    localparam int LS_CNT_W     = 16;
    localparam int LS_NUM_IRQ   = 8;
    localparam int LS_CTRL_WORD = 'h0B0;
    localparam int LS_LINK_WORD = 'h0B1;
    localparam int LS_IRQ_BASE  = 'h0B4;
endpackage

// File: rtl/lstat_rise.sv
// Module: rising-edge detector on a level input.
// Assumes the level is synchronous to clk; the registered copy resets low.
module lstat_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // Hold last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // A rise is high now and low at the previous edge.
    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/lstat_counter.sv
// Module: wrapping event counter with synchronous clear.
// Assumes at most one event per cycle; a clear takes priority over the event.
module lstat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count events, wrapping modulo 2^W; reset and clear win over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/lstat_rdmux.sv
// Module: combinational read-back packing of the statistics counters.
// Assumes DATA_W is a whole multiple of CNT_W; unmapped words read zero.
module lstat_rdmux #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int NUM_IRQ   = 8,
    parameter int LINK_WORD = 'h0B1,
    parameter int IRQ_BASE  = 'h0B4
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CNT_W-1:0]              link_cnt,
    input  logic [NUM_IRQ-1:0][CNT_W-1:0] irq_cnt,
    output logic [DATA_W-1:0]             rdata
);
    localparam int PER_WORD  = DATA_W / CNT_W;
    localparam int NUM_WORDS = (NUM_IRQ + PER_WORD - 1) / PER_WORD;

    // Select and pack the addressed word; everything else reads zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(LINK_WORD))
            rdata[CNT_W-1:0] = link_cnt;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr == ADDR_W'(IRQ_BASE + w)) begin
                for (int s = 0; s < PER_WORD; s++) begin
                    if (w * PER_WORD + s < NUM_IRQ)
                        rdata[s*CNT_W +: CNT_W] = irq_cnt[w*PER_WORD + s];
                end
            end
        end
    end
endmodule

// File: rtl/link_evt_stats.sv
// Module: top of the link-enable and interrupt event statistics block.
// Assumes event inputs and the register port are synchronous to clk.
// Interrupt events count only while link_en is high; masks are not seen here.
module link_evt_stats
    import lstat_pkg::*;
#(
    parameter int ADDR_W  = LS_ADDR_W,
    parameter int DATA_W  = LS_DATA_W,
    parameter int CNT_W   = LS_CNT_W,
    parameter int NUM_IRQ = LS_NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_en,
    input  logic [NUM_IRQ-1:0] irq_evt,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    logic                         clr_all;
    logic                         link_rise;
    logic [CNT_W-1:0]             link_cnt;
    logic [NUM_IRQ-1:0][CNT_W-1:0] irq_cnt;
    logic                         unused_wdata_hi;

    // Write-one-to-clear on bit 0 of the control word.
    assign clr_all = reg_wr && (reg_addr == ADDR_W'(LS_CTRL_WORD)) && reg_wdata[0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:1];

    lstat_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (link_en),
        .rise  (link_rise)
    );

    lstat_counter #(.W(CNT_W)) u_link_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .inc   (link_rise),
        .cnt   (link_cnt)
    );

    // One counter per interrupt source, gated by the link level.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        lstat_counter #(.W(CNT_W)) u_irq_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_all),
            .inc   (irq_evt[g] & link_en),
            .cnt   (irq_cnt[g])
        );
    end

    lstat_rdmux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .NUM_IRQ   (NUM_IRQ),
        .LINK_WORD (LS_LINK_WORD),
        .IRQ_BASE  (LS_IRQ_BASE)
    ) u_rdmux (
        .addr     (reg_addr),
        .link_cnt (link_cnt),
        .irq_cnt  (irq_cnt),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/lstat_checker.sv
// Module: property checker for link_evt_stats, attached with bind.
// Assumes the default package configuration (two counters per word).
module lstat_checker
    import lstat_pkg::*;
#(
    parameter int ADDR_W  = LS_ADDR_W,
    parameter int DATA_W  = LS_DATA_W,
    parameter int CNT_W   = LS_CNT_W,
    parameter int NUM_IRQ = LS_NUM_IRQ
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          link_en,
    input logic [NUM_IRQ-1:0]            irq_evt,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic                          reg_wr,
    input logic                          wbit0,
    input logic [DATA_W-1:0]             reg_rdata,
    input logic [CNT_W-1:0]              link_cnt,
    input logic [NUM_IRQ-1:0][CNT_W-1:0] irq_cnt
);
    localparam int NUM_WORDS = NUM_IRQ / (DATA_W / CNT_W);

    logic clr_req;
    logic unmapped;
    assign clr_req  = reg_wr && (reg_addr == ADDR_W'(LS_CTRL_WORD)) && wbit0;
    assign unmapped = (reg_addr != ADDR_W'(LS_LINK_WORD)) &&
                      ((reg_addr < ADDR_W'(LS_IRQ_BASE)) ||
                       (reg_addr >= ADDR_W'(LS_IRQ_BASE + NUM_WORDS)));

    // R5, R6: a clear empties every counter, even with events on the same edge.
    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (link_cnt == '0) && (irq_cnt == '0));

    // R2: the link counter only ever steps by zero or one.
    assert_link_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> (link_cnt == $past(link_cnt)) ||
                     (link_cnt == $past(link_cnt) + CNT_W'(1)));

    // R4: no interrupt total moves while the link is off.
    assert_irq_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en && !clr_req) |=> (irq_cnt == $past(irq_cnt)));

    // R8: unmapped addresses and the control word read zero.
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (reg_rdata == '0));

    // R3, R7: a counted event adds one modulo 2^16.
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chk
        assert_irq_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (link_en && irq_evt[k] && !clr_req) |=>
                (irq_cnt[k] == CNT_W'($past(irq_cnt[k]) + CNT_W'(1))));
    end
endmodule

bind link_evt_stats lstat_checker u_lstat_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_en   (link_en),
    .irq_evt   (irq_evt),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wbit0     (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .link_cnt  (link_cnt),
    .irq_cnt   (irq_cnt)
);

// File: tb/tb_link_evt_stats.sv
// Bench: sweeps event patterns and register accesses with an arithmetic model.
module tb_link_evt_stats;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_en = 1'b0;
    logic [7:0]  irq_evt = '0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    logic [15:0] m_link = '0;
    logic [15:0] m_irq [8];
    logic        m_prev = 1'b0;

    always #10 clk = ~clk;

    link_evt_stats dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en   (link_en),
        .irq_evt   (irq_evt),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // One clock of stimulus, starting and ending at a falling edge; the model follows.
    task automatic step(input logic le, input logic [7:0] ev, input logic wr,
                        input logic [9:0] a, input logic [31:0] wd);
        link_en = le; irq_evt = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        if (wr && a == 10'h0B0 && wd[0]) begin
            m_link = '0;
            for (int k = 0; k < 8; k++) m_irq[k] = '0;
        end else begin
            if (le && !m_prev) m_link = m_link + 16'd1;
            for (int k = 0; k < 8; k++) if (le && ev[k]) m_irq[k] = m_irq[k] + 16'd1;
        end
        m_prev = le;
        reg_wr = 1'b0; irq_evt = '0; reg_wdata = '0;
    endtask

    task automatic check_word(input logic [9:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check_word(10'h0B1, {16'h0, m_link}, tag);
        for (int w = 0; w < 4; w++)
            check_word(10'(10'h0B4 + w), {m_irq[2*w+1], m_irq[2*w]}, tag);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_irq[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: zero after reset.
        check_all("R1");
        // R8: control word and unmapped addresses read zero.
        check_word(10'h0B0, 32'h0, "R8");
        check_word(10'h000, 32'h0, "R8");
        check_word(10'h0B2, 32'h0, "R8");
        check_word(10'h0B3, 32'h0, "R8");
        check_word(10'h0B8, 32'h0, "R8");
        check_word(10'h3FF, 32'h0, "R8");
        // R4: events with the link off are ignored.
        for (int i = 0; i < 5; i++) step(1'b0, 8'hFF, 1'b0, 10'h0, 32'h0);
        check_all("R4");
        // R2: three rising edges, long high periods add nothing.
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 8'h00, 1'b0, 10'h0, 32'h0);
            step(1'b1, 8'h00, 1'b0, 10'h0, 32'h0);
            step(1'b0, 8'h00, 1'b0, 10'h0, 32'h0);
        end
        check_all("R2");
        // R3: all 256 event patterns with the link on.
        for (int p = 0; p < 256; p++) step(1'b1, 8'(p), 1'b0, 10'h0, 32'h0);
        check_all("R3 sweep");
        // R3: distinct per-source totals expose the packing order.
        for (int k = 0; k < 8; k++)
            for (int n = 0; n <= k; n++) step(1'b1, 8'(1 << k), 1'b0, 10'h0, 32'h0);
        check_all("R3 packing");
        // R9: read data follows the address within the cycle.
        check_word(10'h0B7, {m_irq[7], m_irq[6]}, "R9");
        check_word(10'h0B4, {m_irq[1], m_irq[0]}, "R9");
        // R8: repeated reads leave the totals as they were.
        check_all("R8 reread");
        // R5: writes that must not clear.
        step(1'b1, 8'h00, 1'b1, 10'h0B0, 32'hFFFF_FFFE);
        step(1'b1, 8'h00, 1'b1, 10'h0B1, 32'h0000_0001);
        step(1'b1, 8'h00, 1'b1, 10'h0B4, 32'hFFFF_FFFF);
        check_all("R5 noclear");
        // R5: a proper clear.
        step(1'b1, 8'h00, 1'b1, 10'h0B0, 32'h0000_0001);
        check_all("R5 clear");
        // R6: rebuild totals, then clear on the same edge as a rise and all events.
        step(1'b0, 8'h00, 1'b0, 10'h0, 32'h0);
        for (int i = 0; i < 4; i++) step(1'b1, 8'hA5, 1'b0, 10'h0, 32'h0);
        step(1'b0, 8'h00, 1'b0, 10'h0, 32'h0);
        step(1'b1, 8'hFF, 1'b1, 10'h0B0, 32'h0000_0001);
        check_all("R6");
        // R7: drive one source to 0xFFFF, then wrap it.
        for (int i = 0; i < 65535; i++) step(1'b1, 8'h01, 1'b0, 10'h0, 32'h0);
        check_word(10'h0B4, 32'h0000_FFFF, "R7 max");
        step(1'b1, 8'h01, 1'b0, 10'h0, 32'h0);
        check_word(10'h0B4, 32'h0000_0000, "R7 wrap");
        check_all("R7");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule